// File: doc/BRIEF.md
# Serial Control Port Register Bank

This block is a four-wire serial slave that lets an external controller read and write a bank of sixteen byte-wide registers. The controller drives a serial clock `sclk`, an active-high select `ssel` and a receive line `sdi`. The block answers on a transmit line `sdo`, which is three-state: `sdo_oe` enables the pad driver. Every access begins with a command byte that carries a read/write flag and a register address. A data byte follows. The two bytes may travel in one continuous 16-bit select window (merged access). They may also travel in two windows: the address window closes after exactly eight bits, and the next window carries only the data byte (split access).

The lower registers are control registers. They are held in flops and presented in parallel to the core on `ctrl_o`. The top registers are status registers. They mirror the core's `stat_i` inputs and cannot be written. The serial pins are brought into the `clk` domain through two-flop synchronisers, and the serial clock edges are detected there. The serial clock must therefore run well below `clk`.

The control state machine has five states:
- IDLE: no frame is open.
- CMD: the command byte is being shifted in.
- DATA: the data byte is being transferred.
- HOLD: an address has been latched between windows.
- DONE: the data byte is complete.

Its transitions are:
- IDLE→CMD on a select rise.
- CMD→IDLE on a select fall.
- CMD→DATA on the eighth command bit.
- DATA→DONE on the eighth data bit.
- DATA→HOLD on a select fall with no data bits taken.
- DATA→IDLE on a select fall part-way through the data byte.
- HOLD→DATA on a select rise.
- DONE→IDLE on a select fall.

Top module: `srb_bank`

## Requirements
- R1: The bank has sixteen 8-bit registers, addressed 0 to 15. Registers 0 to 11 are control registers that reset to 0x00. Register i appears on `ctrl_o[8*i+7:8*i]`.
- R2: While `ssel` is high, `sdi` is sampled on each rising `sclk` edge, MSB first. In the command byte, bit 7 = 1 means read and 0 means write, bits 6:4 are ignored, and bits 3:0 are the register address.
- R3: In a merged access, the command byte and the data byte are sent back to back within one select window of 16 clocks.
- R4: If `ssel` falls right after the eighth command bit, the flag and address are kept. The next select window carries only the 8-bit data byte for that register.
- R5: A write reaches the register only once all eight data bits have been sampled. If `ssel` falls earlier, the register keeps its value and the next window starts a new command.
- R6: Registers 12 to 15 read as `stat_i[8*(a-12)+7:8*(a-12)]`. Writes to them change nothing.
- R7: `sdo_oe` is high only during the data byte of a read. While it is low, `sdo` is 0.
- R8: Read data leaves MSB first, and `sdo` changes only after falling `sclk` edges. In a merged read, D7 appears after the first falling edge that follows the eighth command bit. In a split read, D7 appears when the data window opens.
- R9: Clocks that arrive after the eighth data bit, while `ssel` stays high, are ignored until `ssel` falls.
- R10: A select window that closes part-way through the command byte keeps no address. The next window begins a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; must be much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller, idle low |
| ssel | input | 1 | Active-high select; frames the transfer windows |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data, valid while `sdo_oe` is high |
| sdo_oe | output | 1 | Drive enable for the three-state transmit pad |
| stat_i | input | 32 | Status bytes for registers 12 to 15 |
| ctrl_o | output | 96 | Control registers 0 to 11, packed |

## Verification
Two functions can land in the same core cycle:
- the write commit caused by the eighth data bit;
- the close of the select window.

The bench provokes this by raising `sclk` for the last data bit and lowering `ssel` on the same core clock. Both edges then pass through synchronisers of equal depth and reach the state machine together. The reference model expects the byte to be committed. The per-clock comparison of `ctrl_o` and a later read-back of the same register judge the result.

// File: rtl/srb_pkg.sv
package srb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_HOLD,
        ST_DONE
    } srb_state_t;
endpackage

// File: rtl/srb_sync.sv
// Brings the serial pins into the core clock domain and detects their edges.
module srb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic ssel,
    input  logic sdi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_rise,
    output logic sel_fall,
    output logic sdi_smp
);
    logic [2:0] sck_q;
    logic [2:0] sel_q;
    logic [1:0] sdi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= '0;
            sel_q <= '0;
            sdi_q <= '0;
        end else begin
            sck_q <= {sck_q[1:0], sclk};
            sel_q <= {sel_q[1:0], ssel};
            sdi_q <= {sdi_q[0], sdi};
        end
    end

    assign sck_rise = sck_q[1] & ~sck_q[2];
    assign sck_fall = ~sck_q[1] & sck_q[2];
    assign sel_rise = sel_q[1] & ~sel_q[2];
    assign sel_fall = ~sel_q[1] & sel_q[2];
    assign sdi_smp  = sdi_q[1];
endmodule

// File: rtl/srb_fsm.sv
// Frame state machine: command/data shifting, read-data serialisation.
module srb_fsm
    import srb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sel_rise,
    input  logic              sel_fall,
    input  logic              sdi_smp,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe,
    output srb_state_t        state
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    srb_state_t        nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-2:0] sh_in;
    logic [DATA_W-1:0] sh_out;
    logic [DATA_W-1:0] full;
    logic [ADDR_W-1:0] addr;
    logic              rw;
    logic              live;

    assign full = {sh_in, sdi_smp};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (sel_rise) nxt = ST_CMD;
            ST_CMD: begin
                if (sel_fall)                      nxt = ST_IDLE;
                else if (sck_rise && cnt == LAST)  nxt = ST_DATA;
            end
            ST_DATA: begin
                if (sel_fall)                      nxt = (cnt == '0) ? ST_HOLD : ST_IDLE;
                else if (sck_rise && cnt == LAST)  nxt = ST_DONE;
            end
            ST_HOLD: if (sel_rise) nxt = ST_DATA;
            ST_DONE: if (sel_fall) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh_in  <= '0;
            sh_out <= '0;
            addr   <= '0;
            rw     <= 1'b0;
            live   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (sel_rise) cnt <= '0;
                ST_CMD: begin
                    if (sck_rise) begin
                        sh_in <= full[DATA_W-2:0];
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            rw     <= full[DATA_W-1];
                            addr   <= full[ADDR_W-1:0];
                            sh_out <= rd_data;
                            live   <= 1'b0;
                        end
                    end
                end
                ST_DATA: begin
                    if (sck_rise) begin
                        sh_in <= full[DATA_W-2:0];
                        cnt   <= cnt + 1'b1;
                    end else if (sck_fall) begin
                        if (live) sh_out <= {sh_out[DATA_W-2:0], 1'b0};
                        live <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (sel_rise) begin
                        sh_out <= rd_data;
                        live   <= 1'b1;
                        cnt    <= '0;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
            if (sel_fall) cnt <= '0;
        end
    end

    assign rd_addr = (state == ST_CMD) ? full[ADDR_W-1:0] : addr;
    assign wr_en   = (state == ST_DATA) && sck_rise && !rw && (cnt == LAST);
    assign wr_addr = addr;
    assign wr_data = full;
    assign sdo_oe  = (state == ST_DATA) && rw && live;
    assign sdo     = sdo_oe & sh_out[DATA_W-1];
endmodule

// File: rtl/srb_regfile.sv
// Control flops plus read-only status mirror.
module srb_regfile #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int STAT_BASE = 12
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic [ADDR_W-1:0]                      rd_addr,
    output logic [DATA_W-1:0]                      rd_data,
    input  logic [((1<<ADDR_W)-STAT_BASE)*DATA_W-1:0] stat_i,
    output logic [STAT_BASE*DATA_W-1:0]            ctrl_o
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] ctrl_q [STAT_BASE];

    for (genvar g = 0; g < STAT_BASE; g++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    ctrl_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))       ctrl_q[g] <= wr_data;
        end
        assign ctrl_o[g*DATA_W +: DATA_W] = ctrl_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < STAT_BASE; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = ctrl_q[i];
        for (int i = STAT_BASE; i < NREG; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = stat_i[(i-STAT_BASE)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/srb_bank.sv
module srb_bank
    import srb_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int STAT_BASE = 12
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      sclk,
    input  logic                                      ssel,
    input  logic                                      sdi,
    output logic                                      sdo,
    output logic                                      sdo_oe,
    input  logic [((1<<ADDR_W)-STAT_BASE)*DATA_W-1:0] stat_i,
    output logic [STAT_BASE*DATA_W-1:0]               ctrl_o
);
    logic              sck_rise, sck_fall, sel_rise, sel_fall, sdi_smp;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    srb_state_t        state;

    srb_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ssel(ssel), .sdi(sdi),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sel_rise(sel_rise), .sel_fall(sel_fall), .sdi_smp(sdi_smp)
    );

    srb_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sel_rise(sel_rise), .sel_fall(sel_fall), .sdi_smp(sdi_smp),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .state(state)
    );

    srb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_BASE(STAT_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .stat_i(stat_i), .ctrl_o(ctrl_o)
    );
endmodule

// File: rtl/srb_bank_chk.sv
module srb_bank_chk
    import srb_pkg::*;
#(
    parameter int CTRL_W = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdo_oe,
    input logic              wr_en,
    input logic [CTRL_W-1:0] ctrl_o,
    input srb_state_t        state
);
    // R5: control outputs move only on a completed write
    assert_commit_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o != $past(ctrl_o)) |-> $past(wr_en));

    // R9: a committed write leaves the frame closed to further data
    assert_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state == ST_DONE || state == ST_IDLE));

    // R9: the done state never drives and only exits to idle
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> ((state == ST_DONE || state == ST_IDLE) && !sdo_oe));

    // R4: a latched address waits for the data window only
    assert_hold_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state == ST_HOLD || state == ST_DATA));

    // R7: the transmit pad is only enabled inside a data phase
    assert_drive_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (state == ST_DATA));
endmodule

bind srb_bank srb_bank_chk #(.CTRL_W(STAT_BASE*DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sdo_oe(sdo_oe), .wr_en(wr_en),
    .ctrl_o(ctrl_o), .state(state)
);

// File: tb/tb_srb_bank.sv
`timescale 1ns/1ps
module tb_srb_bank;
    localparam int HP = 8;   // core clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, ssel = 1'b0, sdi = 1'b0;
    logic        sdo, sdo_oe;
    logic [31:0] stat_i = 32'h4D_2B_E7_19;
    logic [95:0] ctrl_o;

    int n_chk = 0, n_err = 0;
    bit cmp_on = 0, hold_cmp = 0, done = 0;
    logic [7:0] mreg [16];

    always #2.5 clk = ~clk;

    srb_bank dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .ssel(ssel), .sdi(sdi),
                  .sdo(sdo), .sdo_oe(sdo_oe), .stat_i(stat_i), .ctrl_o(ctrl_o));

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] pack_model();
        logic [95:0] v;
        for (int i = 0; i < 12; i++) v[i*8 +: 8] = mreg[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a < 12) return mreg[a];
        return stat_i[(a-12)*8 +: 8];
    endfunction

    // Reference comparison of the parallel outputs on every clock (R1, R5)
    always @(negedge clk)
        if (cmp_on && !hold_cmp) chk("R5 ctrl_o vs model", ctrl_o, pack_model());

    // One serial bit: low phase, optional sample, high phase, optional sample
    task automatic sbit(input logic b, input bit lo_c, input logic lo_oe, input logic lo_b,
                        input bit hi_c, input logic hi_oe, input logic hi_b, input string req);
        sdi = b;
        wclk(HP);
        if (lo_c) begin
            chk({req, " oe"}, {95'd0, sdo_oe}, {95'd0, lo_oe});
            chk({req, " sdo"}, {95'd0, sdo}, {95'd0, lo_oe & lo_b});
        end
        sclk = 1'b1;
        wclk(HP);
        if (hi_c) begin
            chk({req, " oe(high)"}, {95'd0, sdo_oe}, {95'd0, hi_oe});
            chk({req, " sdo(high)"}, {95'd0, sdo}, {95'd0, hi_oe & hi_b});
        end
        sclk = 1'b0;
    endtask

    task automatic send_cmd(input bit rd, input logic [3:0] a);
        logic [7:0] cmd = {rd, 3'b101, a};   // R2: bits 6:4 are don't-care
        for (int i = 7; i >= 0; i--)
            sbit(cmd[i], 1, 1'b0, 1'b0, (i == 0), 1'b0, 1'b0, "R7 cmd phase");
    endtask

    task automatic send_data(input bit rd, input logic [3:0] a, input logic [7:0] d,
                             input int nbits, input bit late);
        logic [7:0] e = exp_read(a);
        for (int k = 0; k < nbits; k++) begin
            int i = 7 - k;
            if (i == 0 && late && !rd) begin
                sdi = d[0];
                wclk(HP);
                hold_cmp = 1;
                sclk = 1'b1; ssel = 1'b0;     // last edge and select drop together
                wclk(HP);
                sclk = 1'b0;
            end else begin
                if (i == 0) hold_cmp = 1;
                sbit(rd ? 1'b0 : d[i], 1, rd, e[i], (rd && i != 0), rd, e[i],
                     rd ? "R8 read bit" : "R7 write bit");
            end
        end
        if (!rd && nbits == 8 && a < 12) mreg[a] = d;
        hold_cmp = 0;
    endtask

    task automatic frame16(input bit rd, input logic [3:0] a, input logic [7:0] d,
                           input bit extra, input bit late);
        ssel = 1'b1; wclk(HP);
        send_cmd(rd, a);
        send_data(rd, a, d, 8, late);
        if (extra)   // R9: trailing clocks are ignored
            for (int i = 7; i >= 0; i--)
                sbit(~d[i], 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R9 trailing bit");
        ssel = 1'b0; wclk(HP);
    endtask

    task automatic split(input bit rd, input logic [3:0] a, input logic [7:0] d, input int nbits);
        ssel = 1'b1; wclk(HP);
        send_cmd(rd, a);
        ssel = 1'b0; wclk(HP);
        ssel = 1'b1; wclk(HP);
        send_data(rd, a, d, nbits, 0);
        ssel = 1'b0; wclk(HP);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
        wclk(10);
        rst_n = 1'b1;
        wclk(5);
        chk("R1 reset ctrl_o", ctrl_o, 96'd0);
        chk("R7 reset oe", {95'd0, sdo_oe}, 96'd0);
        cmp_on = 1;

        frame16(0, 4'd3, 8'hA5, 0, 0);            // R3 merged write
        frame16(1, 4'd3, 8'h00, 0, 0);            // R3 R8 merged read
        split(0, 4'd11, 8'h3C, 8);                // R4 split write
        split(1, 4'd11, 8'h00, 8);                // R4 split read
        split(0, 4'd0, 8'hF0, 4);                 // R5 aborted data byte
        frame16(1, 4'd0, 8'h00, 0, 0);            // R5 register unchanged
        frame16(0, 4'd13, 8'hFF, 0, 0);           // R6 write ignored
        frame16(1, 4'd13, 8'h00, 0, 0);           // R6 reads status
        split(1, 4'd15, 8'h00, 8);                // R6 split status read
        frame16(0, 4'd7, 8'h81, 1, 0);            // R9 trailing clocks
        frame16(1, 4'd7, 8'h00, 0, 0);
        // R10: select drops mid-command; next window is a new command
        ssel = 1'b1; wclk(HP);
        for (int i = 0; i < 4; i++) sbit(1'b1, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R10 partial cmd");
        ssel = 1'b0; wclk(HP);
        frame16(0, 4'd5, 8'h5A, 0, 0);
        frame16(1, 4'd5, 8'h00, 0, 0);            // R10 fresh command honoured
        frame16(0, 4'd2, 8'hC3, 0, 1);            // last edge with select drop
        frame16(1, 4'd2, 8'h00, 0, 0);
        for (int i = 0; i < 12; i++) frame16(0, 4'(i), 8'(i * 17 + 1), 0, 0);  // R1 all ctrl
        chk("R1 full bank", ctrl_o, pack_model());
        stat_i = 32'h0F_1E_2D_3C;
        frame16(1, 4'd12, 8'h00, 0, 0);           // R6 live status value
        frame16(1, 4'd9, 8'h00, 0, 0);            // R2 read of written ctrl
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        wclk(150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=complete");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule